// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive half of an I2C target. It oversamples the SDA and SCL lines with the system clock, finds start and stop conditions, and compares the first byte after each start with a programmed 7-bit own address plus a write direction bit. Once it is addressed, it shifts in each data byte and hands it to the host through a receive register with a full flag. On the bus it only ever pulls a line low or releases it.

The shift register and the host-visible receive register are separate. The address byte is posted to the host as well, and the host reads it and throws it away. If the host has not emptied the receive register by the time the 8th SCL falling edge of a frame arrives, the slave holds SCL low until the register is read. The acknowledge level is programmable. It is captured once per frame, so a change made while the bus is stalled takes effect on the following frame.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset both open-drain enables are 0, the control register (host address 0) and own-address register (host address 1) read 0, and the status register (host address 2, bit 0 = full) reads 0.
- R2: Unless control bit 0 (enable) and control bit 1 (receive mode) are both 1, the slave never pulls SDA or SCL low, never acknowledges and never sets the full flag.
- R3: The own address is held in bits 7:1 of host address 1. The first byte after a start matches when its bits 7:1 equal that address and its bit 0 (R/W) is 0. On a match with control bit 2 at 0, the slave pulls SDA low from the 8th SCL falling edge to the 9th, so the master sees an acknowledge at the 9th clock.
- R4: A first byte whose address differs, or whose R/W bit is 1, is not acknowledged. SDA stays released and the full flag stays 0 for that frame and for every later frame until the next start.
- R5: At the 9th SCL rising edge of a matching address frame, the full flag becomes 1 and the receive register (host address 3) holds the address byte itself, including its R/W bit.
- R6: In each later frame the slave samples SDA at SCL rising edges 1 to 8, first bit into bit 7. At the 9th rising edge the byte moves to the receive register and the full flag is set. No byte is ever posted while the flag is still 1.
- R7: A read strobe at host address 3 returns the received byte and clears the full flag. Reading any other address leaves the flag unchanged.
- R8: If the full flag is 1 at the 8th SCL falling edge of a frame, the slave holds SCL low until the receive register is read and releases it within two clocks of the read. If the flag is 0 at that edge, SCL is not held.
- R9: Control bit 2 selects the acknowledge level: 0 pulls SDA low, 1 releases it. Reception and posting continue either way. The level is captured at each frame's 8th falling edge, so a change written during a stretch applies to the next frame.
- R10: A stop (SDA rising while SCL is high) releases both lines and returns the slave to idle, where clocked bytes are ignored. A repeated start restarts address matching, even after an ignored transfer.
- R11: SDA is pulled low only in the acknowledge slot. It is never pulled low while the master clocks data bits 1 to 8, and it only starts being pulled after an SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch), 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (clears full when reading address 3) |
| host_addr | input | 2 | Host register address: 0 control, 1 own address, 2 status, 3 receive data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr, combinational |

## Verification
The bench goes after the stall path: it leaves a byte unread, clocks the next frame's 8 bits, raises SCL from the master side and checks that the line stays low and the pending byte survives. A design that tested the flag at the 9th edge instead of the 8th fall would overwrite that byte. The bench rewrites the acknowledge level during the stall and expects the old level on the current frame. A design that read the control bit live would flip that acknowledge. Mismatched addresses, read-direction addresses, bytes clocked with no start, and a repeated start after an ignored transfer catch a slave that keeps matching on data frames or fails to re-arm. Seeded random transfers, each with a random own address, acknowledge level and byte count, cover the ordinary path against bench-computed acknowledges and posted bytes.

// File: rtl/i2c_rx_pkg.sv
// Shared constants and types for the I2C slave receiver.
// Assumes a 7-bit address and byte-wide host registers.
package i2c_rx_pkg;
    localparam int DATA_W    = 8;
    localparam int HOST_AW   = 2;
    localparam int CNT_W     = 4;
    localparam int CTRL_EN   = 0;
    localparam int CTRL_RX   = 1;
    localparam int CTRL_NACK = 2;
    localparam logic [HOST_AW-1:0] REG_CTRL = 2'd0;
    localparam logic [HOST_AW-1:0] REG_OWN  = 2'd1;
    localparam logic [HOST_AW-1:0] REG_STAT = 2'd2;
    localparam logic [HOST_AW-1:0] REG_DATA = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2c_rx_sync.sv
// Line synchronizer: passes one bus line through STAGES flops and
// flags its rising and falling edges, one clock per edge.
// Assumes STAGES >= 2. Resets to the idle-high bus level.
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the chain and keep the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/i2c_rx_hostif.sv
// Host register port: control and own-address registers, the receive
// data register and its full flag. A posted byte sets full; a read
// strobe at the data address clears it. Read data is combinational.
module i2c_rx_hostif
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              post_valid,
    input  logic [DATA_W-1:0] post_data,
    output logic              active,
    output logic              nack_level,
    output logic [DATA_W-2:0] own_addr,
    output logic              full
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] own_q;
    logic [DATA_W-1:0] rdr_q;
    logic              full_q;

    // Host writes to the control and own-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            own_q  <= '0;
        end else if (host_we) begin
            if (host_addr == REG_CTRL) ctrl_q <= host_wdata;
            if (host_addr == REG_OWN)  own_q  <= host_wdata;
        end
    end

    // Receive register and full flag; a post takes priority over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_q  <= '0;
            full_q <= 1'b0;
        end else if (post_valid) begin
            rdr_q  <= post_data;
            full_q <= 1'b1;
        end else if (host_re && host_addr == REG_DATA) begin
            full_q <= 1'b0;
        end
    end

    // Read data mux.
    always_comb begin
        case (host_addr)
            REG_CTRL: host_rdata = ctrl_q;
            REG_OWN:  host_rdata = own_q;
            REG_STAT: host_rdata = {{(DATA_W-1){1'b0}}, full_q};
            default:  host_rdata = rdr_q;
        endcase
    end

    assign active     = ctrl_q[CTRL_EN] & ctrl_q[CTRL_RX];
    assign nack_level = ctrl_q[CTRL_NACK];
    assign own_addr   = own_q[DATA_W-1:1];
    assign full       = full_q;
endmodule

// File: rtl/i2c_rx_engine.sv
// Bus-side receive engine: start/stop detection, bit counting, address
// match, acknowledge drive and clock stretching. Assumes synchronized
// lines whose SCL phases last several system clocks.
module i2c_rx_engine
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              nack_level,
    input  logic              full,
    output logic              post_valid,
    output logic [DATA_W-1:0] post_data,
    output logic              stop_det,
    output logic              sda_oe,
    output logic              scl_oe
);
    localparam logic [CNT_W-1:0] ACK_AT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] END_AT = CNT_W'(DATA_W + 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shift;
    logic              ack_q;
    logic              stretch_q;
    logic              start_det;
    logic              in_frame;
    logic              addr_hit;

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign in_frame  = (state == ST_ADDR) || (state == ST_DATA);
    assign addr_hit  = (shift[DATA_W-1:1] == own_addr) && !shift[0];

    // Frame sequencing, ack drive and stretch control.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shift     <= '0;
            ack_q     <= 1'b0;
            stretch_q <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            cnt       <= '0;
            ack_q     <= 1'b0;
            stretch_q <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ack_q     <= 1'b0;
            stretch_q <= 1'b0;
        end else begin
            if (!full) stretch_q <= 1'b0;
            if (in_frame && scl_rise) begin
                if (cnt < ACK_AT) shift <= {shift[DATA_W-2:0], sda_lvl};
                if (cnt < END_AT) cnt <= cnt + 1'b1;
            end
            if (in_frame && scl_fall) begin
                if (cnt == ACK_AT) begin
                    if (state == ST_ADDR && !addr_hit) begin
                        state <= ST_SKIP;
                        ack_q <= 1'b0;
                    end else begin
                        ack_q <= ~nack_level;
                        if (full) stretch_q <= 1'b1;
                    end
                end else if (cnt == END_AT) begin
                    cnt   <= '0;
                    ack_q <= 1'b0;
                    if (state == ST_ADDR) state <= ST_DATA;
                end
            end
        end
    end

    assign post_valid = active && in_frame && scl_rise && (cnt == ACK_AT)
                        && !start_det && !stop_det;
    assign post_data  = shift;
    assign sda_oe     = active & ack_q;
    assign scl_oe     = stretch_q;
endmodule

// File: rtl/i2c_slave_rx.sv
// Top of the I2C slave receiver: two line synchronizers, the receive
// engine and the host register port. Outputs are open-drain enables.
module i2c_slave_rx
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               scl_oe,
    output logic               sda_oe,
    input  logic               host_we,
    input  logic               host_re,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata
);
    logic              scl_lvl, scl_rise, scl_fall;
    logic              sda_lvl, sda_rise, sda_fall;
    logic              active, nack_level, rx_full;
    logic              post_valid, stop_det;
    logic [DATA_W-1:0] post_data;
    logic [DATA_W-2:0] own_addr;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    i2c_rx_engine u_engine (
        .clk(clk), .rst_n(rst_n), .active(active),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .own_addr(own_addr), .nack_level(nack_level), .full(rx_full),
        .post_valid(post_valid), .post_data(post_data), .stop_det(stop_det),
        .sda_oe(sda_oe), .scl_oe(scl_oe)
    );

    i2c_rx_hostif u_hostif (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .post_valid(post_valid), .post_data(post_data), .active(active),
        .nack_level(nack_level), .own_addr(own_addr), .full(rx_full)
    );
endmodule

// File: rtl/i2c_rx_checker.sv
// Protocol checker for the I2C slave receiver, bound to the top.
// Relates the engine's bus outputs to the host-side full flag.
module i2c_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic active,
    input logic sda_oe,
    input logic scl_oe,
    input logic full,
    input logic scl_rise,
    input logic scl_fall,
    input logic stop_det,
    input logic post_valid
);
    // R2: a disabled slave lets go of both lines.
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sda_oe && !scl_oe));

    // R5: the full flag only rises just after an SCL rising edge.
    p_full_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(scl_rise));

    // R6: a byte is never posted over an unread one.
    p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> !full);

    // R8: SCL is let go in the cycle after the register is emptied.
    p_release_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |=> !scl_oe);

    // R10: a stop releases both lines.
    p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> (!sda_oe && !scl_oe));

    // R11: SDA drive only begins after an SCL falling edge.
    p_ack_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
endmodule

bind i2c_slave_rx i2c_rx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .sda_oe(sda_oe),
    .scl_oe(scl_oe), .full(rx_full), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .stop_det(stop_det), .post_valid(post_valid)
);

// File: tb/i2c_slave_rx_test.sv
// Self-checking bench: a bus master model on wired-AND lines plus host
// register tasks; expected values come from bench functions.
module i2c_slave_rx_test;
    import i2c_rx_pkg::*;

    localparam int Q = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic       scl_m, sda_m;
    logic       scl_oe, sda_oe;
    logic       host_we, host_re;
    logic [1:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    wire        scl_line = scl_m & ~scl_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    i2c_slave_rx uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic logic addr_matches(input logic [7:0] b, input logic [7:0] own_reg);
        return (b[7:1] == own_reg[7:1]) && !b[0];
    endfunction

    function automatic logic exp_ack(input logic matched, input logic nack);
        return matched ? nack : 1'b1;
    endfunction

    function automatic logic [7:0] ctrl_word(input logic en, input logic rx, input logic nack);
        return {5'b0, nack, rx, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_re = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        wait (scl_line == 1'b1);
        tick(Q / 2);
        chk("R11 sda not driven in data bit", sda_oe, 1'b0);
        tick(Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic ack_clock(output logic ack);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1;
        wait (scl_line == 1'b1);
        tick(Q / 2);
        ack = sda_line;
        tick(Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic xfer_byte(input logic [7:0] b, output logic ack);
        send_bits(b);
        ack_clock(ack);
    endtask

    logic [7:0] rd, own, abyte, d0, d1, d2;
    logic       ack, m, nack;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        host_we = 1'b0; host_re = 1'b0; host_addr = '0; host_wdata = '0;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 scl_oe", scl_oe, 1'b0);
        chk("R1 sda_oe", sda_oe, 1'b0);
        host_read(REG_CTRL, rd); chk("R1 ctrl", rd, 8'h00);
        host_read(REG_OWN, rd);  chk("R1 own", rd, 8'h00);
        host_read(REG_STAT, rd); chk("R1 status", rd, 8'h00);

        own = {7'h2A, 1'b0};
        host_write(REG_OWN, own);
        host_read(REG_OWN, rd); chk("R3 own readback", rd, own);

        // R2: enable off, then receive mode off
        host_write(REG_CTRL, ctrl_word(1'b0, 1'b1, 1'b0));
        bus_start(); xfer_byte(own, ack); bus_stop();
        chk("R2 no ack when disabled", ack, 1'b1);
        host_read(REG_STAT, rd); chk("R2 full stays 0", rd, 8'h00);
        host_write(REG_CTRL, ctrl_word(1'b1, 1'b0, 1'b0));
        bus_start(); xfer_byte(own, ack); bus_stop();
        chk("R2 no ack without rx mode", ack, 1'b1);
        host_read(REG_STAT, rd); chk("R2 full stays 0 rx off", rd, 8'h00);

        // R3/R5/R6/R7: normal write transfer
        host_write(REG_CTRL, ctrl_word(1'b1, 1'b1, 1'b0));
        bus_start();
        send_bits(own);
        chk("R8 no stretch when empty", scl_oe, 1'b0);
        ack_clock(ack);
        chk("R3 address ack", ack, exp_ack(1'b1, 1'b0));
        host_read(REG_STAT, rd); chk("R5 full after address", rd, 8'h01);
        host_read(REG_STAT, rd); chk("R7 status read keeps full", rd, 8'h01);
        host_read(REG_DATA, rd); chk("R5 dummy address byte", rd, own);
        host_read(REG_STAT, rd); chk("R7 full cleared by read", rd, 8'h00);
        d0 = 8'hA5;
        xfer_byte(d0, ack);
        chk("R6 data ack", ack, 1'b0);
        host_read(REG_DATA, rd); chk("R6 data byte msb first", rd, d0);

        // R8: stretch while previous byte unread
        d0 = 8'h3C; d1 = 8'hC3;
        xfer_byte(d0, ack);
        send_bits(d1);
        chk("R8 stretch at 8th fall", scl_oe, 1'b1);
        scl_m = 1'b1; tick(40);
        chk("R8 scl held low", scl_line, 1'b0);
        host_read(REG_STAT, rd); chk("R6 pending byte kept full", rd, 8'h01);
        host_read(REG_DATA, rd); chk("R6 pending byte intact", rd, d0);
        tick(2);
        chk("R8 released after read", scl_oe, 1'b0);
        ack_clock(ack);
        chk("R6 ack after stretch", ack, 1'b0);
        host_read(REG_DATA, rd); chk("R6 stretched byte", rd, d1);

        // R9: level written during stretch applies one frame later
        d0 = 8'h11; d1 = 8'h22; d2 = 8'h44;
        xfer_byte(d0, ack);
        send_bits(d1);
        chk("R8 second stretch", scl_oe, 1'b1);
        host_write(REG_CTRL, ctrl_word(1'b1, 1'b1, 1'b1));
        host_read(REG_DATA, rd); chk("R6 byte before level change", rd, d0);
        ack_clock(ack);
        chk("R9 old level kept for current frame", ack, 1'b0);
        host_read(REG_DATA, rd); chk("R6 byte under old level", rd, d1);
        xfer_byte(d2, ack);
        chk("R9 new level on next frame", ack, 1'b1);
        host_read(REG_DATA, rd); chk("R9 nack byte still posted", rd, d2);
        host_write(REG_CTRL, ctrl_word(1'b1, 1'b1, 1'b0));
        xfer_byte(d0, ack);
        chk("R9 ack restored", ack, 1'b0);
        host_read(REG_DATA, rd); chk("R6 byte after restore", rd, d0);
        bus_stop();
        tick(3);
        chk("R10 sda released after stop", sda_oe, 1'b0);
        chk("R10 scl released after stop", scl_oe, 1'b0);

        // R4: wrong address, then read direction
        bus_start();
        xfer_byte({7'h2B, 1'b0}, ack); chk("R4 mismatch nack", ack, 1'b1);
        xfer_byte(own, ack); chk("R4 later frame ignored", ack, 1'b1);
        host_read(REG_STAT, rd); chk("R4 full stays 0", rd, 8'h00);
        bus_stop();
        bus_start();
        xfer_byte({7'h2A, 1'b1}, ack); chk("R4 read direction nack", ack, 1'b1);
        host_read(REG_STAT, rd); chk("R4 full stays 0 read dir", rd, 8'h00);
        bus_stop();

        // R10: clocked byte with no start, then repeated start
        xfer_byte(own, ack); chk("R10 idle ignores bytes", ack, 1'b1);
        host_read(REG_STAT, rd); chk("R10 idle no post", rd, 8'h00);
        bus_start();
        xfer_byte({7'h11, 1'b0}, ack); chk("R4 other address", ack, 1'b1);
        bus_start();
        xfer_byte(own, ack); chk("R10 repeated start matches", ack, 1'b0);
        host_read(REG_DATA, rd); chk("R10 address after repeated start", rd, own);
        bus_stop();

        // Random transfers
        for (int t = 0; t < 25; t++) begin
            own  = {7'($urandom_range(1, 127)), 1'($urandom_range(0, 1))};
            nack = 1'($urandom_range(0, 1));
            host_write(REG_OWN, own);
            host_write(REG_CTRL, ctrl_word(1'b1, 1'b1, nack));
            abyte = ($urandom_range(0, 2) == 0) ? 8'($urandom) : {own[7:1], 1'b0};
            if ($urandom_range(0, 3) == 0) abyte[0] = 1'b1;
            m = addr_matches(abyte, own);
            bus_start();
            xfer_byte(abyte, ack);
            chk("R3 random address ack", ack, exp_ack(m, nack));
            host_read(REG_STAT, rd); chk("R5 random full after address", rd, {7'b0, m});
            if (m) begin
                host_read(REG_DATA, rd); chk("R5 random address byte", rd, abyte);
            end
            for (int k = 0, n = $urandom_range(1, 3); k < n; k++) begin
                d0 = 8'($urandom);
                xfer_byte(d0, ack);
                chk("R6 random data ack", ack, exp_ack(m, nack));
                host_read(REG_STAT, rd); chk("R4 random full", rd, {7'b0, m});
                if (m) begin
                    host_read(REG_DATA, rd); chk("R6 random data", rd, d0);
                end
            end
            bus_stop();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule